// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block is the read-path status logic of a parallel NOR flash device. While an internal program or erase runs, or while an erase is suspended, a host polls the part by issuing reads. The block answers each read with a status word built from the current operation mode, the byte being programmed, whether the read hits the affected sector, and whether the operation has run past its time limit. At all other times it passes the array data through unchanged.

Each read is marked by a rising edge of the read strobe, sampled on the clock. The answer is registered at that edge and holds until the next read. Two toggle flags give a polling host proof that the device is still busy. One advances on every status read. The other advances only on reads that land in the sector being erased or suspended. Both clear when a new operation starts.

The operation mode is an encoded input: `2'b00` program, `2'b01` erase, `2'b10` erase-suspend read, `2'b11` erase-suspend program. The mode may change while an operation is active, for example when an erase is suspended, and the toggle flags keep their values across such a change.

Top module: `flash_status_gen`

## Requirements
- R1: In program mode (`2'b00`) with an operation active, bit 7 of the read result is the inverse of bit 7 of `pend_data`.
- R2: In erase mode (`2'b01`) a status read returns bit 7 = 0 and bit 3 = 1. In program mode it returns bit 3 = 0 and bit 2 = 1.
- R3: In program, erase and suspend-program modes, bit 6 alternates on successive status reads whatever address is read. The first read after an operation starts returns bit 6 = 0.
- R4: Bit 5 equals `time_over` in program, erase and suspend-program modes. It reads 0 in suspend-read mode.
- R5: In erase mode, bit 2 shows the sector toggle flag. This flag flips only on reads with `sector_hit` = 1, and reads with `sector_hit` = 0 leave it unchanged.
- R6: In suspend-read mode (`2'b10`), a read with `sector_hit` = 1 returns bits 7..3 = 1,1,0,0,0 and bit 2 = the sector toggle flag, which then flips. A read with `sector_hit` = 0 returns `array_data` and advances no toggle.
- R7: In suspend-program mode (`2'b11`), bit 7 is the inverse of `pend_data[7]`, bit 3 is 0, and bit 2 equals `sector_hit`, which here marks a read of the byte being programmed.
- R8: Bits 4, 1 and 0 of every status word are 0.
- R9: With no operation active, which covers before any `op_start` and after `op_done`, a read returns `array_data`. An `op_start` clears both toggle flags.
- R10: After reset `rd_data` is 0. `rd_data` changes only on the clock edge that sees a rising edge of `rd_strobe` and becomes visible one cycle after the strobe rises. A strobe held high captures and advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 2 | Operation mode: 00 program, 01 erase, 10 suspend read, 11 suspend program |
| op_start | input | 1 | Pulse: a new internal operation begins (clears the toggle flags) |
| op_done | input | 1 | Pulse: the internal operation has completed |
| time_over | input | 1 | Operation has exceeded its time limit |
| sector_hit | input | 1 | Read address lies in the affected sector (the programmed byte in mode 11) |
| pend_data | input | 8 | Byte being programmed |
| array_data | input | 8 | Array contents at the read address |
| rd_strobe | input | 1 | Read strobe; each rising edge is one read |
| rd_data | output | 8 | Registered read result |

## Verification
The state that is hardest to reach is a sector toggle flag that differs from the read toggle flag. That flag holds a meaningful value when the mode moves from erase into suspend-read without a fresh start. The stimulus mixes reads with `sector_hit` set and cleared during an erase so that the two toggles go out of step. It then switches the mode to suspend-read and to suspend-program without pulsing `op_start`, so the inherited flag values show on bits 6 and 2. A strobe held high for several cycles checks that an access counts only once.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    MODE_PROG    = 2'b00,
    MODE_ERASE   = 2'b01,
    MODE_SUSP_RD = 2'b10,
    MODE_SUSP_PG = 2'b11
  } fs_mode_e;

  localparam int STAT_W   = 8;
  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_TMO  = 5;
  localparam int BIT_KIND = 3;
  localparam int BIT_SECT = 2;

  localparam int TOG_READ = 0;
  localparam int TOG_SECT = 1;
  localparam int NUM_TOG  = 2;

  // Status word for a read, given the mode and flag state.
  function automatic logic [STAT_W-1:0] fs_status_word(
    input fs_mode_e mode,
    input logic     pend_msb,
    input logic     tog_read,
    input logic     tog_sect,
    input logic     tmo,
    input logic     hit
  );
    logic [STAT_W-1:0] w;
    w = '0;
    unique case (mode)
      MODE_PROG: begin
        w[BIT_POLL] = ~pend_msb;
        w[BIT_TOG]  = tog_read;
        w[BIT_TMO]  = tmo;
        w[BIT_KIND] = 1'b0;
        w[BIT_SECT] = 1'b1;
      end
      MODE_ERASE: begin
        w[BIT_POLL] = 1'b0;
        w[BIT_TOG]  = tog_read;
        w[BIT_TMO]  = tmo;
        w[BIT_KIND] = 1'b1;
        w[BIT_SECT] = tog_sect;
      end
      MODE_SUSP_RD: begin
        w[BIT_POLL] = 1'b1;
        w[BIT_TOG]  = 1'b1;
        w[BIT_TMO]  = 1'b0;
        w[BIT_KIND] = 1'b0;
        w[BIT_SECT] = tog_sect;
      end
      default: begin
        w[BIT_POLL] = ~pend_msb;
        w[BIT_TOG]  = tog_read;
        w[BIT_TMO]  = tmo;
        w[BIT_KIND] = 1'b0;
        w[BIT_SECT] = hit;
      end
    endcase
    return w;
  endfunction

  // Is the status word (rather than array data) returned?
  function automatic logic fs_status_visible(input logic active, input fs_mode_e mode,
                                             input logic hit);
    return active && !(mode == MODE_SUSP_RD && !hit);
  endfunction

  // Does a read advance the read toggle?
  function automatic logic fs_read_tog_steps(input fs_mode_e mode);
    return mode != MODE_SUSP_RD;
  endfunction

  // Does a read advance the sector toggle?
  function automatic logic fs_sect_tog_steps(input fs_mode_e mode, input logic hit);
    return hit && (mode == MODE_ERASE || mode == MODE_SUSP_RD);
  endfunction

endpackage

// File: rtl/fs_read_edge.sv
module fs_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/fs_op_tracker.sv
module fs_op_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic op_done,
  output logic active
);
  always_ff @(posedge clk) begin
    if (!rst_n)        active <= 1'b0;
    else if (op_start) active <= 1'b1;
    else if (op_done)  active <= 1'b0;
  end
endmodule

// File: rtl/fs_toggle_bank.sv
module fs_toggle_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] adv,
  output logic [N-1:0] tog
);
  for (genvar i = 0; i < N; i++) begin : g_tog
    always_ff @(posedge clk) begin
      if (!rst_n || clear) tog[i] <= 1'b0;
      else if (adv[i])     tog[i] <= ~tog[i];
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              time_over,
  input  logic              sector_hit,
  input  logic [STAT_W-1:0] pend_data,
  input  logic [STAT_W-1:0] array_data,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] rd_data
);
  fs_mode_e          mode;
  logic              rd_rise;
  logic              op_active;
  logic              status_sel;
  logic [NUM_TOG-1:0] tog_adv;
  logic [NUM_TOG-1:0] tog;
  logic [STAT_W-1:0] status_word;

  assign mode = fs_mode_e'(op_mode);

  fs_read_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (rd_strobe),
    .rise   (rd_rise)
  );

  fs_op_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_done  (op_done),
    .active   (op_active)
  );

  assign tog_adv[TOG_READ] = rd_rise && op_active && fs_read_tog_steps(mode);
  assign tog_adv[TOG_SECT] = rd_rise && op_active && fs_sect_tog_steps(mode, sector_hit);

  fs_toggle_bank #(.N(NUM_TOG)) u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (op_start),
    .adv   (tog_adv),
    .tog   (tog)
  );

  assign status_sel  = fs_status_visible(op_active, mode, sector_hit);
  assign status_word = fs_status_word(mode, pend_data[STAT_W-1], tog[TOG_READ],
                                      tog[TOG_SECT], time_over, sector_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_rise) rd_data <= status_sel ? status_word : array_data;
  end
endmodule

// File: rtl/fs_status_checker.sv
module fs_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_rise,
  input logic       op_active,
  input logic [1:0] op_mode,
  input logic       time_over,
  input logic       sector_hit,
  input logic [7:0] pend_data,
  input logic [7:0] array_data,
  input logic [7:0] rd_data
);
  AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && op_mode == 2'b00 |=> rd_data[7] == ~$past(pend_data[7])); // R1

  AST_ERASE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && op_mode == 2'b01 |=> !rd_data[7] && rd_data[3]); // R2

  AST_TIME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && op_mode != 2'b10 |=> rd_data[5] == $past(time_over)); // R4

  AST_SUSP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && op_mode == 2'b10 && sector_hit |=> rd_data[7:3] == 5'b11000); // R6

  AST_SUSP_PG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && op_mode == 2'b11 |=> rd_data[2] == $past(sector_hit)); // R7

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && op_active && !(op_mode == 2'b10 && !sector_hit)
      |=> rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00); // R8

  AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && !op_active |=> rd_data == $past(array_data)); // R9

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(rd_data)); // R10
endmodule

bind flash_status_gen fs_status_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_rise    (rd_rise),
  .op_active  (op_active),
  .op_mode    (op_mode),
  .time_over  (time_over),
  .sector_hit (sector_hit),
  .pend_data  (pend_data),
  .array_data (array_data),
  .rd_data    (rd_data)
);

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic       op_start = 1'b0;
  logic       op_done = 1'b0;
  logic       time_over = 1'b0;
  logic       sector_hit = 1'b0;
  logic [7:0] pend_data = 8'h00;
  logic [7:0] array_data = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_gen uut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_start(op_start),
    .op_done(op_done), .time_over(time_over), .sector_hit(sector_hit),
    .pend_data(pend_data), .array_data(array_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data)
  );

  // Behavioural reference, evaluated once per clock from the requirements.
  int m_busy = 0, m_flip = 0, m_area = 0, m_last = 0;
  int m_out = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_flip = 0; m_area = 0; m_last = 0; m_out = 0;
    end else begin
      int mode_i;
      mode_i = int'(op_mode);
      if (rd_strobe && m_last == 0) begin
        if (m_busy != 0 && !(mode_i == 2 && !sector_hit)) begin
          int w;
          w = 0;
          if (mode_i == 0)      w = (pend_data[7] ? 0 : 128) + 64*m_flip + 32*time_over + 4;
          else if (mode_i == 1) w = 64*m_flip + 32*time_over + 8 + 4*m_area;
          else if (mode_i == 2) w = 128 + 64 + 4*m_area;
          else                  w = (pend_data[7] ? 0 : 128) + 64*m_flip + 32*time_over + 4*sector_hit;
          m_out = w;
          if (mode_i != 2) m_flip = 1 - m_flip;
          if (sector_hit && (mode_i == 1 || mode_i == 2)) m_area = 1 - m_area;
        end else begin
          m_out = int'(array_data);
        end
      end
      m_last = rd_strobe ? 1 : 0;
      if (op_start) begin
        m_busy = 1; m_flip = 0; m_area = 0;
      end else if (op_done) begin
        m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(rd_data) != m_out) begin
        errors++;
        $display("FAIL R10 per-cycle model: actual=%02h expected=%02h at cycle %0d",
                 rd_data, m_out[7:0], cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_data(input logic [7:0] exp, input string req);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, rd_data, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    expect_data(exp, req);
  endtask

  task automatic pulse_start(input logic [1:0] m);
    @(negedge clk) begin op_mode = m; op_start = 1'b1; end
    @(negedge clk) op_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_data(8'h00, "R10 reset value");
    rst_n = 1'b1;

    // Idle: array data returned
    array_data = 8'hA5;
    do_read(8'hA5, "R9 idle read");

    // Program, pending MSB = 1
    pend_data = 8'h80;
    pulse_start(2'b00);
    do_read(8'h04, "R1 R2 R8 first program read");
    do_read(8'h44, "R3 read toggle flips");
    time_over = 1'b1;
    do_read(8'h24, "R4 time limit flag");
    time_over = 1'b0;
    pend_data = 8'h00;
    do_read(8'hC4, "R1 inverted MSB 0");
    pulse_done();
    array_data = 8'h3C;
    do_read(8'h3C, "R9 after completion");

    // Erase, mixed sector hits
    sector_hit = 1'b1;
    pulse_start(2'b01);
    do_read(8'h08, "R2 erase first read");
    do_read(8'h4C, "R5 sector toggle on hit");
    sector_hit = 1'b0;
    do_read(8'h08, "R5 miss read");
    do_read(8'h48, "R5 sector toggle held on miss");
    sector_hit = 1'b1;
    do_read(8'h08, "R5 hit after misses");

    // Suspend read, no new start
    op_mode = 2'b10;
    do_read(8'hC4, "R6 suspended sector read");
    do_read(8'hC0, "R6 sector toggle flips");
    sector_hit = 1'b0;
    array_data = 8'h5A;
    do_read(8'h5A, "R6 other sector returns array");
    sector_hit = 1'b1;
    time_over = 1'b1;
    do_read(8'hC4, "R4 R6 time flag masked in suspend read");
    time_over = 1'b0;

    // Suspend program
    op_mode = 2'b11;
    pend_data = 8'h00;
    do_read(8'hC4, "R7 programmed byte read");
    sector_hit = 1'b0;
    do_read(8'h80, "R7 other address");

    // Strobe held high: single capture
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) pend_data = 8'h80;
    repeat (3) @(negedge clk);
    expect_data(8'hC0, "R10 held strobe single capture");
    rd_strobe = 1'b0;
    pend_data = 8'h00;
    do_read(8'h80, "R10 toggle advanced once");

    // New operation clears toggles
    pend_data = 8'hFF;
    pulse_start(2'b00);
    do_read(8'h04, "R9 start clears toggles");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule